// File: doc/BRIEF.md
# Direct-Mapped Serial Flash Read Window

This block presents part of a serial memory device as a plain read port. A stored operation template supplies every field of the device operation except the address and the length: the opcode, the number of address bytes, the number of dummy bytes, the lane code and the data direction. A base offset and a window length, both in bytes, fix where the window starts in the device and how far it reaches.

A requester hands over a window-relative offset and a byte count through a valid/ready handshake. The block adds the base offset to the request offset and keeps only as many address bytes as the template sends. It then trims the count so that the access stops at the window end, and issues one operation to a downstream sequencer. The bytes that the sequencer streams back are forwarded in order. A completion pulse carries the number of bytes actually served.

A request that runs past the window end is not an error. It completes with a shorter count, and the requester asks again for the rest. A request that starts at or past the end completes at once with zero. A window whose template is not a read also completes with zero. Only one request is in flight at a time.

Top module: `dmw_read_window`

## Requirements
- R1: Out of reset, reqReady is 1 and seqValid, rdValid and doneValid are 0.
- R2: A request is accepted only when reqValid and reqReady are both 1. reqReady stays 0 from the cycle after acceptance until the cycle after the doneValid pulse, so only one request is outstanding.
- R3: seqAddr equals cfgBase plus reqOffset, keeping only the low 8*cfgAddrBytes bits (cfgAddrBytes from 0 to 4; 0 sends address 0, 4 sends all 32 bits). All higher bits are 0.
- R4: While seqValid is 1, seqOpcode, seqAddrBytes, seqDummyBytes and seqLanes equal the template inputs. seqValid and seqAddr hold steady until seqReady is seen.
- R5: The served count is the lesser of reqLen and cfgLength minus reqOffset. seqLen and doneCount both equal it.
- R6: If reqOffset is greater than or equal to cfgLength, the request completes with doneCount 0 and seqValid is never raised.
- R7: The template direction is coded 0 = none, 1 = read, 2 = write. Any code other than 1 completes every request with doneCount 0 and no operation.
- R8: After the operation is granted, each seqRdValid byte is passed out on rdValid/rdData in the same cycle. Exactly the served count of bytes is passed out.
- R9: doneValid is a one-cycle pulse in the cycle after the last served byte, or after the decision to serve 0 bytes. It carries doneCount.
- R10: A request with reqLen 0 completes with doneCount 0 and no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgOpcode | input | 8 | Template opcode |
| cfgAddrBytes | input | 3 | Template address byte count (0..4) |
| cfgDummyBytes | input | 4 | Template dummy byte count |
| cfgLanes | input | 2 | Template lane code, passed through |
| cfgDir | input | 2 | Template data direction (1 = read) |
| cfgBase | input | 32 | Device byte offset of the window start |
| cfgLength | input | 32 | Window length in bytes |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqOffset | input | 32 | Window-relative byte offset |
| reqLen | input | 16 | Requested byte count |
| seqValid | output | 1 | Operation valid to sequencer |
| seqReady | input | 1 | Sequencer takes the operation |
| seqOpcode | output | 8 | Operation opcode |
| seqAddr | output | 32 | Operation device address |
| seqAddrBytes | output | 3 | Operation address byte count |
| seqDummyBytes | output | 4 | Operation dummy byte count |
| seqLanes | output | 2 | Operation lane code |
| seqLen | output | 16 | Operation data byte count |
| seqRdValid | input | 1 | Read byte from sequencer valid |
| seqRdData | input | 8 | Read byte from sequencer |
| rdValid | output | 1 | Read byte to requester valid |
| rdData | output | 8 | Read byte to requester |
| doneValid | output | 1 | Completion pulse |
| doneCount | output | 16 | Bytes served by the completed request |

## Verification
The bench aims at the window edge. It tries a request that ends inside the window, one that crosses the end, one that starts on the last byte, and ones that start exactly at the end or beyond it. A design with an off-by-one in the remaining-length arithmetic would serve one byte too many or too few. A design that lacks the bound would return bytes from outside the window. It also checks address truncation with a 3-byte template, a non-read template and a zero-length request. A design that got these wrong would put stray high address bits on the bus, or issue an operation where none should go out. Throughout every request it checks that reqReady stays low and that the byte count matches exactly, which catches a second request slipping in or a missing or duplicated byte.

// File: rtl/dmw_pkg.sv
package dmw_pkg;
  localparam logic [1:0] DIR_NONE  = 2'd0;
  localparam logic [1:0] DIR_READ  = 2'd1;
  localparam logic [1:0] DIR_WRITE = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DATA  = 2'd2,
    ST_DONE  = 2'd3
  } dmwState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic countByte;
  } dmwStrobe_t;
endpackage

// File: rtl/dmw_datapath.sv
module dmw_datapath
  import dmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmwStrobe_t        stb,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgLength,
  input  logic [2:0]        cfgAddrBytes,
  input  logic [1:0]        cfgDir,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [LEN_W-1:0]  reqLen,
  output logic [ADDR_W-1:0] seqAddr,
  output logic [LEN_W-1:0]  servedCnt,
  output logic              servedZero,
  output logic              lastByte
);
  localparam int ADDR_BYTES = ADDR_W / 8;

  logic [ADDR_W-1:0] addrMask;
  logic [ADDR_W-1:0] remaining;
  logic [ADDR_W-1:0] reqLenExt;
  logic [LEN_W-1:0]  servedNext;
  logic [ADDR_W-1:0] addrReg;
  logic [LEN_W-1:0]  servedReg;
  logic [LEN_W-1:0]  byteCnt;

  // one mask byte per address byte the template sends
  generate
    for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_mask
      assign addrMask[b*8 +: 8] = (32'(cfgAddrBytes) > b) ? 8'hFF : 8'h00;
    end
  endgenerate

  assign remaining = cfgLength - reqOffset;
  assign reqLenExt = ADDR_W'(reqLen);

  always_comb begin
    if (cfgDir != DIR_READ || reqOffset >= cfgLength || reqLen == '0)
      servedNext = '0;
    else if (reqLenExt <= remaining)
      servedNext = reqLen;
    else
      servedNext = remaining[LEN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      servedReg <= '0;
      byteCnt   <= '0;
    end else if (stb.capture) begin
      addrReg   <= (cfgBase + reqOffset) & addrMask;
      servedReg <= servedNext;
      byteCnt   <= '0;
    end else if (stb.countByte) begin
      byteCnt <= byteCnt + 1'b1;
    end
  end

  assign seqAddr    = addrReg;
  assign servedCnt  = servedReg;
  assign servedZero = (servedReg == '0);
  assign lastByte   = (byteCnt == servedReg - 1'b1);

  // R8: never more bytes counted than served
  p_byte_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.countByte |-> (byteCnt < servedReg));

  // R5: served count never exceeds the captured request length
  p_served_le_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (servedReg <= $past(reqLen)));
endmodule

// File: rtl/dmw_ctrl.sv
module dmw_ctrl
  import dmw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       seqValid,
  input  logic       seqReady,
  input  logic       seqRdValid,
  output logic       rdValid,
  output logic       doneValid,
  input  logic       servedZero,
  input  logic       lastByte,
  output dmwStrobe_t stb
);
  dmwState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext     = state;
    reqReady      = 1'b0;
    seqValid      = 1'b0;
    rdValid       = 1'b0;
    doneValid     = 1'b0;
    stb.capture   = 1'b0;
    stb.countByte = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.capture = 1'b1;
          stateNext   = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (servedZero) stateNext = ST_DONE;
        else begin
          seqValid = 1'b1;
          if (seqReady) stateNext = ST_DATA;
        end
      end
      ST_DATA: begin
        rdValid       = seqRdValid;
        stb.countByte = seqRdValid;
        if (seqRdValid && lastByte) stateNext = ST_DONE;
      end
      ST_DONE: begin
        doneValid = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R2: one outstanding request
  p_one_outstanding_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R2: ready returns right after completion
  p_ready_after_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> reqReady);

  // R4: operation request holds until taken
  p_hold_op_r4: assert property (@(posedge clk) disable iff (!rstN)
    (seqValid && !seqReady) |=> seqValid);

  // R6: no operation for a zero-byte access
  p_no_empty_op_r6: assert property (@(posedge clk) disable iff (!rstN)
    seqValid |-> !servedZero);

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
endmodule

// File: rtl/dmw_read_window.sv
module dmw_read_window
  import dmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        cfgOpcode,
  input  logic [2:0]        cfgAddrBytes,
  input  logic [3:0]        cfgDummyBytes,
  input  logic [1:0]        cfgLanes,
  input  logic [1:0]        cfgDir,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgLength,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              seqValid,
  input  logic              seqReady,
  output logic [7:0]        seqOpcode,
  output logic [ADDR_W-1:0] seqAddr,
  output logic [2:0]        seqAddrBytes,
  output logic [3:0]        seqDummyBytes,
  output logic [1:0]        seqLanes,
  output logic [LEN_W-1:0]  seqLen,
  input  logic              seqRdValid,
  input  logic [7:0]        seqRdData,
  output logic              rdValid,
  output logic [7:0]        rdData,
  output logic              doneValid,
  output logic [LEN_W-1:0]  doneCount
);
  dmwStrobe_t        stb;
  logic              servedZero;
  logic              lastByte;
  logic [LEN_W-1:0]  servedCnt;

  dmw_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqReady  (reqReady),
    .seqValid  (seqValid),
    .seqReady  (seqReady),
    .seqRdValid(seqRdValid),
    .rdValid   (rdValid),
    .doneValid (doneValid),
    .servedZero(servedZero),
    .lastByte  (lastByte),
    .stb       (stb)
  );

  dmw_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .cfgBase     (cfgBase),
    .cfgLength   (cfgLength),
    .cfgAddrBytes(cfgAddrBytes),
    .cfgDir      (cfgDir),
    .reqOffset   (reqOffset),
    .reqLen      (reqLen),
    .seqAddr     (seqAddr),
    .servedCnt   (servedCnt),
    .servedZero  (servedZero),
    .lastByte    (lastByte)
  );

  assign seqOpcode     = cfgOpcode;
  assign seqAddrBytes  = cfgAddrBytes;
  assign seqDummyBytes = cfgDummyBytes;
  assign seqLanes      = cfgLanes;
  assign seqLen        = servedCnt;
  assign rdData        = seqRdData;
  assign doneCount     = servedCnt;

  // R4: address steady while the operation waits
  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (seqValid && !seqReady) |=> $stable(seqAddr));
endmodule

// File: tb/sim_dmw_read_window.sv
module sim_dmw_read_window;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cfgOpcode = 8'h0B;
  logic [2:0]  cfgAddrBytes = 3'd4;
  logic [3:0]  cfgDummyBytes = 4'd1;
  logic [1:0]  cfgLanes = 2'd2;
  logic [1:0]  cfgDir = 2'd1;
  logic [31:0] cfgBase = 32'h1000;
  logic [31:0] cfgLength = 32'h100;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqOffset = '0;
  logic [15:0] reqLen = '0;
  logic        seqValid;
  logic        seqReady = 1'b0;
  logic [7:0]  seqOpcode;
  logic [31:0] seqAddr;
  logic [2:0]  seqAddrBytes;
  logic [3:0]  seqDummyBytes;
  logic [1:0]  seqLanes;
  logic [15:0] seqLen;
  logic        seqRdValid = 1'b0;
  logic [7:0]  seqRdData = '0;
  logic        rdValid;
  logic [7:0]  rdData;
  logic        doneValid;
  logic [15:0] doneCount;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  dmw_read_window u0 (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] devByte(input logic [31:0] a);
    logic [31:0] p;
    p = a * 32'd7 + 32'd3;
    return p[7:0];
  endfunction

  // one request; sequencer model grants and streams bytes
  task automatic runReq(input logic [31:0] off, input logic [15:0] len,
                        input int expServed, input logic [31:0] expAddr, input string tag);
    bit granted = 0;
    bit done = 0;
    int sent = 0;
    int got = 0;
    int opsSeen = 0;
    int badData = 0;
    int busyReady = 0;
    int doneCnt = -1;
    @(negedge clk);
    reqOffset = off; reqLen = len; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int cyc = 0; cyc < 400 && !done; cyc++) begin
      if (doneValid) begin
        doneCnt = int'(doneCount);
        done = 1;
      end
      if (reqReady && !done) busyReady++;
      seqReady = 1'b0;
      seqRdValid = 1'b0;
      if (seqValid && !granted) begin
        opsSeen++;
        chk(seqAddr == expAddr, {tag, " R3 seqAddr"}, seqAddr, expAddr);
        chk(seqOpcode == cfgOpcode && seqDummyBytes == cfgDummyBytes &&
            seqLanes == cfgLanes && seqAddrBytes == cfgAddrBytes,
            {tag, " R4 template fields"}, seqOpcode, cfgOpcode);
        chk(int'(seqLen) == expServed, {tag, " R5 seqLen"}, seqLen, expServed);
        seqReady = 1'b1;
        granted = 1;
      end else if (granted && sent < expServed && !done) begin
        seqRdValid = 1'b1;
        seqRdData = devByte(expAddr + 32'(sent));
        sent++;
      end
      #1;
      if (rdValid) begin
        if (rdData != devByte(expAddr + 32'(got))) badData++;
        got++;
      end
      if (!done) @(negedge clk);
    end
    seqReady = 1'b0; seqRdValid = 1'b0;
    chk(done, {tag, " R9 completion seen"}, done, 1);
    chk(doneCnt == expServed, {tag, " R5 doneCount"}, doneCnt, expServed);
    chk(got == expServed && badData == 0, {tag, " R8 bytes forwarded"}, got, expServed);
    chk(busyReady == 0, {tag, " R2 ready low while busy"}, busyReady, 0);
    if (expServed == 0)
      chk(opsSeen == 0, {tag, " R6 R7 R10 no operation"}, opsSeen, 0);
    @(negedge clk);
    chk(reqReady == 1'b1 && doneValid == 1'b0, {tag, " R2 R9 ready after pulse"}, reqReady, 1);
  endtask

  task automatic testReset();
    chk(reqReady == 1'b1, "R1 reqReady", reqReady, 1);
    chk(!seqValid && !rdValid && !doneValid, "R1 outputs idle",
        {seqValid, rdValid, doneValid}, 0);
  endtask

  task automatic testInside();   runReq(32'h10, 16'd8, 8, 32'h1010, "inside R5");   endtask
  task automatic testCross();    runReq(32'hFC, 16'd10, 4, 32'h10FC, "cross R5");   endtask
  task automatic testLastByte(); runReq(32'hFF, 16'd5, 1, 32'h10FF, "last R5");     endtask
  task automatic testAtEnd();    runReq(32'h100, 16'd4, 0, 32'h0, "atEnd R6");      endtask
  task automatic testBeyond();   runReq(32'h200, 16'd4, 0, 32'h0, "beyond R6");     endtask
  task automatic testZeroLen();  runReq(32'h20, 16'd0, 0, 32'h0, "zeroLen R10");    endtask
  task automatic testAddr3();
    cfgBase = 32'hAB123400; cfgAddrBytes = 3'd3; cfgOpcode = 8'h6B; cfgLanes = 2'd3;
    runReq(32'h10, 16'd3, 3, 32'h00123410, "addr3 R3");
    cfgBase = 32'h1000; cfgAddrBytes = 3'd4; cfgOpcode = 8'h0B; cfgLanes = 2'd2;
  endtask
  task automatic testWriteDir();
    cfgDir = 2'd2;
    runReq(32'h10, 16'd8, 0, 32'h0, "writeDir R7");
    cfgDir = 2'd1;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testInside();
    testCross();
    testLastByte();
    testAtEnd();
    testBeyond();
    testZeroLen();
    testAddr3();
    testWriteDir();
    testInside();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule